// File: doc/BRIEF.md
# Indirect Interrupt Controller Register Window

This block is the register front end of an I/O interrupt controller. Software sees only two 32-bit locations on a simple single-cycle bus. The select location holds an 8-bit code, and the window location reads or writes whichever internal register that code names. The internal registers are a fixed version word, a 4-bit identification value, an arbitration word that mirrors the identification value, and a 64-bit routing entry for each interrupt pin. Each routing entry is reached through two select codes, one for its lower 32 bits and one for its upper 32 bits.

The block keeps the routing table. Each entry carries a vector, a delivery mode, a destination mode, a polarity, a remote-pending flag, a trigger mode, a mask and a destination. Delivery logic outside the block sets the remote-pending flag through a side input. The block also takes a registered copy of each pin's request level. When software writes an entry whose pin has a request pending, the block issues a one-cycle re-evaluate strobe with that pin's index, so the delivery logic can service the pin again under the new settings. Destination decoding and delivery are not part of this block.

Top module: `ioc_regwin`

## Requirements
- R1: After reset the select register reads 0 and the identification value is 0. Every entry reads 0x0001_0000 in its lower half (only the mask, bit 16, is set) and 0 in its upper half. No re-evaluate strobe is issued.
- R2: The bus offset is the low 8 address bits. A write of length 4 or 8 at offset 0x00 loads data bits 7:0 into the select register. A read at offset 0x00 returns the select value zero-extended.
- R3: With select code 0x01, a window read returns (NUM_PINS-1) in bits 23:16 and the version code in bits 7:0, with all other bits 0. This is 0x0017_0011 by default. Window writes under this code change nothing.
- R4: With select code 0x00, a window write stores data bits 27:24 as the identification value, and a window read returns it in bits 27:24 with all other bits 0. Select code 0x02 reads back the same word, and window writes under code 0x02 change nothing.
- R5: A select code s of 0x10 or above addresses entry (s-0x10)>>1. An odd s addresses entry bits 63:32 and an even s addresses bits 31:0. Entry bits are written and read back unchanged, except as R6 states.
- R6: A window write to the lower half of an entry stores remote-pending (bit 14) as 0, whatever the data holds. The side input sets bit 14 of the entry it names. A write to the upper half leaves bit 14 alone.
- R7: A window write whose entry index is NUM_PINS or more changes no entry. A window read at such an index returns 0.
- R8: One cycle after any accepted entry write, if the pin's registered request bit is 1, the block raises its re-evaluate strobe for exactly one cycle with that pin's index. Otherwise it raises no strobe.
- R9: A bus write is accepted only when its length code is 4 or 8. A write with any other length is dropped.
- R10: Read data appears on the cycle after the read request. A read at any offset other than 0x00 or 0x10 returns 0.
- R11: Select codes 0x03 to 0x0F read 0 through the window, and window writes under those codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request, single cycle |
| bus_rd | input | 1 | Read request, single cycle |
| bus_addr | input | ADDR_W | Byte address; the low 8 bits form the offset |
| bus_len | input | 4 | Transfer length in bytes |
| bus_wdata | input | 32 | Low word of the write data |
| bus_rdata | output | 32 | Registered read data |
| pin_req | input | NUM_PINS | Request level of each pin |
| rem_set | input | 1 | Set remote-pending of one entry |
| rem_idx | input | PIN_W | Entry that rem_set targets |
| rsv_vld | output | 1 | Re-evaluate strobe |
| rsv_idx | output | PIN_W | Pin index carried with the strobe |

## Verification
The bench writes data with bit 14 set into a lower half. A design that copied the data as written would then read the remote-pending flag back as 1. It also sets the flag from the side input and then writes the upper half, to catch a design that clears the flag on either half. Writes at index 23 and index 24 check the table boundary. A design with an off-by-one limit would either refuse the last pin or alias the index past the end onto an existing entry. The version, arbitration and unmapped select codes, a 2-byte write and an off-window read are each checked to change or return nothing. The re-evaluate strobe is checked with the request bit both set and clear, which catches a design that fires on every entry write.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  // bus offsets (low 8 address bits)
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  // select codes
  localparam logic [7:0] SEL_IDENT = 8'h00;
  localparam logic [7:0] SEL_VERS  = 8'h01;
  localparam logic [7:0] SEL_ARB   = 8'h02;
  localparam logic [7:0] SEL_TBL0  = 8'h10;
  // entry fields used by this block
  localparam int REM_BIT  = 14;
  localparam int MASK_BIT = 16;
endpackage

// File: rtl/ioc_busdec.sv
module ioc_busdec #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_len,
  output logic              sel_wr,
  output logic              win_wr,
  output logic              sel_rd,
  output logic              win_rd
);
  import ioc_pkg::*;

  logic [7:0] off;
  logic       len_ok;

  assign off    = bus_addr[7:0];
  assign len_ok = (bus_len == 4'd4) || (bus_len == 4'd8);

  always_comb begin
    sel_wr = bus_wr && len_ok && (off == OFF_SEL);
    win_wr = bus_wr && len_ok && (off == OFF_WIN);
    sel_rd = bus_rd && (off == OFF_SEL);
    win_rd = bus_rd && (off == OFF_WIN);
  end

  // R9
  wr_len_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_wr || win_wr) |-> (bus_len == 4'd4 || bus_len == 4'd8));
  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_wr, win_wr}));
endmodule

// File: rtl/ioc_redir_tbl.sv
module ioc_redir_tbl #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 7,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic                hi,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_word,
  input  logic [NUM_PINS-1:0] req_q,
  input  logic                rem_set,
  input  logic [PIN_W-1:0]    rem_idx,
  output logic                rsv_vld,
  output logic [PIN_W-1:0]    rsv_idx
);
  import ioc_pkg::*;

  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_PINS);
  localparam logic [PIN_W-1:0] REM_LIM = PIN_W'(NUM_PINS - 1);
  localparam logic [31:0]      REM_CLR = ~(32'h1 << REM_BIT);

  logic [63:0]      tbl_q [NUM_PINS];
  logic             idx_ok;
  logic [PIN_W-1:0] pin;

  assign idx_ok = (idx < IDX_LIM);
  assign pin    = idx[PIN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) tbl_q[i] <= 64'h1 << MASK_BIT;
      rsv_vld <= 1'b0;
      rsv_idx <= '0;
    end else begin
      if (rem_set && rem_idx <= REM_LIM) tbl_q[rem_idx][REM_BIT] <= 1'b1;
      if (wr_en && idx_ok) begin
        if (hi) tbl_q[pin][63:32] <= wr_data;
        else    tbl_q[pin][31:0]  <= wr_data & REM_CLR;
      end
      rsv_vld <= wr_en && idx_ok && req_q[pin];
      rsv_idx <= pin;
    end
  end

  always_comb begin
    rd_word = 32'h0;
    if (idx_ok) rd_word = hi ? tbl_q[pin][63:32] : tbl_q[pin][31:0];
  end

  // R6
  rem_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_ok && !hi) |=> !tbl_q[$past(pin)][REM_BIT]);
  // R8
  rsv_src_chk: assert property (@(posedge clk) disable iff (rst)
    rsv_vld |-> $past(wr_en && req_q[pin]));
  // R8
  rsv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (rsv_vld && !wr_en) |=> !rsv_vld);
endmodule

// File: rtl/ioc_regwin.sv
module ioc_regwin #(
  parameter int          NUM_PINS = 24,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  VER_CODE = 8'h11,
  localparam int         PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [3:0]          bus_len,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_req,
  input  logic                rem_set,
  input  logic [PIN_W-1:0]    rem_idx,
  output logic                rsv_vld,
  output logic [PIN_W-1:0]    rsv_idx
);
  import ioc_pkg::*;

  localparam int         IDX_W   = 7;
  localparam logic [7:0] TOP_PIN = 8'(NUM_PINS - 1);

  logic                sel_wr, win_wr, sel_rd, win_rd;
  logic [7:0]          sel_q;
  logic [3:0]          id_q;
  logic [NUM_PINS-1:0] req_q;
  logic                is_tbl, id_wr, tbl_wr;
  logic [IDX_W-1:0]    tbl_idx;
  logic [31:0]         tbl_word, win_word;

  ioc_busdec #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_len(bus_len),
    .sel_wr(sel_wr), .win_wr(win_wr), .sel_rd(sel_rd), .win_rd(win_rd)
  );

  assign is_tbl  = (sel_q >= SEL_TBL0);
  assign tbl_idx = sel_q[7:1] - 7'd8;
  assign id_wr   = win_wr && (sel_q == SEL_IDENT);
  assign tbl_wr  = win_wr && is_tbl;

  ioc_redir_tbl #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(tbl_wr), .idx(tbl_idx), .hi(sel_q[0]),
    .wr_data(bus_wdata), .rd_word(tbl_word), .req_q(req_q),
    .rem_set(rem_set), .rem_idx(rem_idx), .rsv_vld(rsv_vld), .rsv_idx(rsv_idx)
  );

  always_comb begin
    win_word = 32'h0;
    if (is_tbl)                                        win_word = tbl_word;
    else if (sel_q == SEL_VERS)                        win_word = {8'h00, TOP_PIN, 8'h00, VER_CODE};
    else if (sel_q == SEL_IDENT || sel_q == SEL_ARB)   win_word = {4'h0, id_q, 24'h0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 8'h00;
      id_q      <= 4'h0;
      req_q     <= '0;
      bus_rdata <= 32'h0;
    end else begin
      req_q <= pin_req;
      if (sel_wr) sel_q <= bus_wdata[7:0];
      if (id_wr)  id_q  <= bus_wdata[27:24];
      if (bus_rd) bus_rdata <= sel_rd ? {24'h0, sel_q} : (win_rd ? win_word : 32'h0);
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == 8'h00 && id_q == 4'h0 && !rsv_vld));
  // R2
  sel_only_by_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> $past(sel_wr));
  // R4
  id_only_by_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(id_q) |-> $past(win_wr && sel_q == SEL_IDENT));
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_ioc_regwin.sv
`timescale 1ns/1ps
module test_ioc_regwin;
  localparam int NUM_PINS = 24;
  localparam int PIN_W    = $clog2(NUM_PINS);

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  addr;
    logic [3:0]  len;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  // walked in order; each row is a write (is_rd=0) or a checked read
  localparam vec_t VECS [0:24] = '{
    '{1'b0, 8'h00, 4'd4, 32'h0000_0001, 32'h0, 4'd3},  // R3 select version
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0017_0011, 4'd3},
    '{1'b0, 8'h10, 4'd4, 32'hFFFF_FFFF, 32'h0, 4'd3},  // R3 write ignored
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0017_0011, 4'd3},
    '{1'b0, 8'h00, 4'd8, 32'h0000_0000, 32'h0, 4'd4},  // R4 select ident
    '{1'b0, 8'h10, 4'd4, 32'h5A00_0000, 32'h0, 4'd4},
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0A00_0000, 4'd4},
    '{1'b0, 8'h00, 4'd4, 32'h0000_0002, 32'h0, 4'd4},  // R4 arbitration
    '{1'b0, 8'h10, 4'd4, 32'h0300_0000, 32'h0, 4'd4},
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0A00_0000, 4'd4},
    '{1'b0, 8'h00, 4'd4, 32'h0000_0013, 32'h0, 4'd5},  // R5 entry 1 upper
    '{1'b0, 8'h10, 4'd8, 32'hC100_0000, 32'h0, 4'd5},
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'hC100_0000, 4'd5},
    '{1'b0, 8'h00, 4'd4, 32'h0000_0012, 32'h0, 4'd1},  // R1 entry 1 lower
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0001_0000, 4'd1},
    '{1'b0, 8'h10, 4'd2, 32'h0000_0033, 32'h0, 4'd9},  // R9 2-byte dropped
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0001_0000, 4'd9},
    '{1'b0, 8'h10, 4'd4, 32'h0000_E931, 32'h0, 4'd6},  // R6 bit 14 forced low
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0000_A931, 4'd6},
    '{1'b1, 8'h04, 4'd4, 32'h0,         32'h0, 4'd10},         // R10 other offset
    '{1'b1, 8'h00, 4'd4, 32'h0,         32'h0000_0012, 4'd2},  // R2 select readback
    '{1'b0, 8'h00, 4'd4, 32'h0000_0005, 32'h0, 4'd11},         // R11 unmapped code
    '{1'b0, 8'h10, 4'd4, 32'h0F00_0000, 32'h0, 4'd11},
    '{1'b1, 8'h10, 4'd4, 32'h0,         32'h0, 4'd11},
    '{1'b1, 8'h20, 4'd4, 32'h0,         32'h0, 4'd10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [3:0] bus_len = 4'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [NUM_PINS-1:0] pin_req = '0;
  logic rem_set = 1'b0;
  logic [PIN_W-1:0] rem_idx = '0;
  logic rsv_vld;
  logic [PIN_W-1:0] rsv_idx;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic last_rsv_vld;
  logic [PIN_W-1:0] last_rsv_idx;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  ioc_regwin i_ioc_regwin (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_req(pin_req), .rem_set(rem_set), .rem_idx(rem_idx),
    .rsv_vld(rsv_vld), .rsv_idx(rsv_idx)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [3:0] l, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_len = l; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    last_rsv_vld = rsv_vld;
    last_rsv_idx = rsv_idx;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_len = 4'd4;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 no strobe", {31'h0, rsv_vld}, 32'h0);
    do_rd(8'h00, rv); chk("R1 select", rv, 32'h0);
    do_rd(8'h10, rv); chk("R1 ident", rv, 32'h0);
    do_wr(8'h00, 4'd4, 32'h3E);
    do_rd(8'h10, rv); chk("R1 entry23 low", rv, 32'h0001_0000);
    do_wr(8'h00, 4'd4, 32'h3F);
    do_rd(8'h10, rv); chk("R1 entry23 high", rv, 32'h0);

    for (int i = 0; i < 25; i++) begin
      if (VECS[i].is_rd) begin
        do_rd(VECS[i].addr, rv);
        chk($sformatf("R%0d vec%0d", VECS[i].rq, i), rv, VECS[i].exp);
      end else begin
        do_wr(VECS[i].addr, VECS[i].len, VECS[i].data);
      end
    end

    // R7 table boundary: entry 23 writable, entry 24 discarded
    do_wr(8'h00, 4'd4, 32'h3F);
    do_wr(8'h10, 4'd4, 32'h7700_0000);
    do_rd(8'h10, rv); chk("R7 entry23 high", rv, 32'h7700_0000);
    do_wr(8'h00, 4'd4, 32'h41);
    do_wr(8'h10, 4'd4, 32'h1111_1111);
    do_rd(8'h10, rv); chk("R7 entry24 reads 0", rv, 32'h0);
    do_wr(8'h00, 4'd4, 32'h10);
    do_rd(8'h10, rv); chk("R7 entry0 untouched", rv, 32'h0001_0000);
    do_wr(8'h00, 4'd4, 32'h3F);
    do_rd(8'h10, rv); chk("R7 entry23 kept", rv, 32'h7700_0000);

    // R6 side input sets, upper write keeps, lower write clears
    @(negedge clk); rem_set = 1'b1; rem_idx = PIN_W'(1);
    @(negedge clk); rem_set = 1'b0;
    do_wr(8'h00, 4'd4, 32'h12);
    do_rd(8'h10, rv); chk("R6 remote set", rv, 32'h0000_E931);
    do_wr(8'h00, 4'd4, 32'h13);
    do_wr(8'h10, 4'd4, 32'h2200_0000);
    chk("R8 no strobe without request", {31'h0, last_rsv_vld}, 32'h0);
    do_wr(8'h00, 4'd4, 32'h12);
    do_rd(8'h10, rv); chk("R6 upper write keeps flag", rv, 32'h0000_E931);

    // R8 strobe with request pending on pin 1
    @(negedge clk); pin_req = NUM_PINS'(2);
    do_wr(8'h10, 4'd4, 32'h0000_E931);
    chk("R8 strobe", {31'h0, last_rsv_vld}, 32'h1);
    chk("R8 strobe index", 32'(last_rsv_idx), 32'h1);
    @(negedge clk);
    chk("R8 single cycle", {31'h0, rsv_vld}, 32'h0);
    do_rd(8'h10, rv); chk("R6 lower write clears", rv, 32'h0000_A931);
    do_wr(8'h10, 4'd1, 32'h0);
    chk("R9 dropped write no strobe", {31'h0, last_rsv_vld}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule